// File: doc/BRIEF.md
# Display-Data Channel Segmented Burst Reader

This block is the command engine that sits above a byte-level I2C master and fetches display identification data from a monitor. Software programs a packed target-address word (segment number, segment-pointer device, starting word offset and data device), a byte count and a command code. It may empty the receive FIFO, and then writes the control word with the start and enable bits set. The engine walks the bus sequence for an explicit-offset read by itself. The returned bytes land in a receive FIFO that software drains through a pop port.

A non-zero segment first gets a segment-pointer write. After that the engine writes the word offset to the data device, issues a repeated start, and reads up to sixteen bytes. On the last byte it tells the master to answer with NACK. A 128-byte block is therefore fetched as eight back-to-back bursts, with software advancing the offset by sixteen between them. The start bit reads back through `busy` until the command ends. `done` then says whether every byte the engine wrote was acknowledged. Bit-level SCL/SDA timing is left to the master.

Register select codes on the write port: 0 control, 1 target address, 2 FIFO control, 3 byte count, 4 command.

Top module: `edid_burst_rd`

## Requirements
- R1: After reset `busy`, `done` and `req_valid` are 0 and the FIFO is empty.
- R2: A control write with bit 31 (enable) and bit 30 (start) both set, while idle, and with the command register holding 4 (explicit-offset read), makes `busy` read 1 from the next cycle until the command ends. With bit 31 clear, or with any other command code, the write leaves `busy` at 0 and produces no bus request.
- R3: Target-address word: segment in bits 31:24, segment-pointer device in 23:16, word offset in 15:8, data device in 7:0. Devices are 7-bit, sent as `{addr[6:0], rw}`. Request ops: 0 start (also repeated start), 1 write byte, 2 read byte, 3 stop. With a non-zero segment the requests are: start, write `{spa,0}`, write segment, start, write `{dev,0}`, write offset, start, write `{dev,1}`, N reads, stop.
- R4: With segment 0, the first start and the two segment-pointer writes are left out, and the command begins at the start that precedes `{dev,0}`.
- R5: N is the byte-count register (bits 7:0) clamped to 16. A count of 0 reads nothing and goes straight from `{dev,1}` to stop.
- R6: `req_last` is 1 on the final read of a burst and on no other request.
- R7: Each read response byte is pushed into the FIFO. `fifo_data` shows the oldest byte, and `fifo_rd` removes it, so bytes come out in bus order.
- R8: `done` is cleared when a command starts and is set when the stop of a fully acknowledged command completes.
- R9: Writing FIFO control with bit 31 set empties the FIFO.
- R10: A control write with bit 0 set aborts any command on the next cycle. `busy`, `done` and `req_valid` go to 0 and the FIFO empties. The bit is not stored.
- R11: While waiting for a response, the engine holds `req_valid`, `req_op` and `req_byte` steady.
- R12: A write that is not acknowledged (`rsp_ack`=0) makes the next request a stop. After that stop `busy` clears and `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Start bit read-back, 1 while a command runs |
| done | output | 1 | Transfer completed successfully |
| fifo_rd | input | 1 | Pop the oldest FIFO byte |
| fifo_data | output | 8 | Oldest FIFO byte |
| fifo_empty | output | 1 | FIFO holds no bytes |
| fifo_level | output | $clog2(FIFO_DEPTH+1) | Bytes held in FIFO |
| req_valid | output | 1 | Request to byte master pending |
| req_op | output | 2 | Request op: 0 start, 1 write, 2 read, 3 stop |
| req_byte | output | 8 | Byte to write |
| req_last | output | 1 | Read answered with NACK (last byte) |
| rsp_valid | input | 1 | Master finished the current request (one cycle) |
| rsp_ack | input | 1 | Target acknowledged a written byte |
| rsp_byte | input | 8 | Byte returned by a read |

## Verification
If the step sequencer holds a wrong state, the request stream to the byte master shows it on the very next response. Examples are a segment write on segment 0, a missing repeated start, or a read with the wrong NACK marking. Each burst's full op trace is therefore compared with a list computed from the programmed address and count. A wrong remaining-byte count or FIFO pointer shows up as a wrong `fifo_level` or wrong byte values when the burst is drained. The bench checks both against an arithmetic model of the display's memory. Failure handling is observed through `busy` and `done` within a few cycles of the injected NACK.

// File: rtl/edid_burst_rd.sv
module edid_burst_rd #(
  parameter int FIFO_DEPTH = 16,
  parameter int MAX_BURST  = 16,
  parameter int CMD_EORD   = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              reg_we,
  input  logic [2:0]                        reg_sel,
  input  logic [31:0]                       reg_wdata,
  output logic                              busy,
  output logic                              done,
  input  logic                              fifo_rd,
  output logic [7:0]                        fifo_data,
  output logic                              fifo_empty,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]   fifo_level,
  output logic                              req_valid,
  output logic [1:0]                        req_op,
  output logic [7:0]                        req_byte,
  output logic                              req_last,
  input  logic                              rsp_valid,
  input  logic                              rsp_ack,
  input  logic [7:0]                        rsp_byte
);
  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int RW = $clog2(MAX_BURST + 1);
  localparam int LW = $clog2(FIFO_DEPTH + 1);

  localparam logic [1:0] OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3;
  localparam logic [3:0] ST_SEG_S = 4'd0, ST_SEG_A = 4'd1, ST_SEG_V = 4'd2, ST_DEV_S = 4'd3,
                         ST_DEV_W = 4'd4, ST_OFF = 4'd5, ST_RS = 4'd6, ST_DEV_R = 4'd7,
                         ST_READ = 4'd8, ST_STOP = 4'd9;

  logic [31:0]   addr_q;
  logic [7:0]    cnt_q, cmd_q;
  logic          busy_q, done_q, fail_q;
  logic [3:0]    step_q;
  logic [RW-1:0] rem_q, cnt_eff;
  logic [7:0]    mem [FIFO_DEPTH];
  logic [AW:0]   wp_q, rp_q;

  wire [7:0] seg = addr_q[31:24];
  wire [7:0] spa = addr_q[23:16];
  wire [7:0] off = addr_q[15:8];
  wire [7:0] dev = addr_q[7:0];

  wire ctrl_wr  = reg_we && reg_sel == 3'd0;
  wire srst     = ctrl_wr && reg_wdata[0];
  wire go       = ctrl_wr && reg_wdata[31] && reg_wdata[30] && !reg_wdata[0] && !busy_q
                  && cmd_q == 8'(CMD_EORD);
  wire fifo_clr = reg_we && reg_sel == 3'd2 && reg_wdata[31];
  wire take     = busy_q && rsp_valid;
  wire is_wr    = req_op == OP_WRITE;
  wire full     = fifo_level == LW'(FIFO_DEPTH);
  wire push     = take && step_q == ST_READ && !full;
  wire pop      = fifo_rd && !fifo_empty;

  wire unused_bits = ^{reg_wdata[29:1], spa[7], dev[7]};

  assign cnt_eff    = (cnt_q > 8'(MAX_BURST)) ? RW'(MAX_BURST) : cnt_q[RW-1:0];
  assign busy       = busy_q;
  assign done       = done_q;
  assign req_valid  = busy_q;
  assign req_last   = busy_q && step_q == ST_READ && rem_q == RW'(1);
  assign fifo_level = LW'(wp_q - rp_q);
  assign fifo_empty = wp_q == rp_q;
  assign fifo_data  = mem[rp_q[AW-1:0]];

  always_comb begin
    req_op   = OP_WRITE;
    req_byte = 8'h00;
    case (step_q)
      ST_SEG_S, ST_DEV_S, ST_RS: req_op = OP_START;
      ST_SEG_A: req_byte = {spa[6:0], 1'b0};
      ST_SEG_V: req_byte = seg;
      ST_DEV_W: req_byte = {dev[6:0], 1'b0};
      ST_OFF:   req_byte = off;
      ST_DEV_R: req_byte = {dev[6:0], 1'b1};
      ST_READ:  req_op = OP_READ;
      default:  req_op = OP_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      cmd_q  <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        3'd1: addr_q <= reg_wdata;
        3'd3: cnt_q  <= reg_wdata[7:0];
        3'd4: cmd_q  <= reg_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      step_q <= ST_STOP;
      rem_q  <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      rem_q  <= cnt_eff;
      step_q <= (seg != 8'd0) ? ST_SEG_S : ST_DEV_S;
    end else if (take) begin
      if (is_wr && !rsp_ack) begin
        fail_q <= 1'b1;
        step_q <= ST_STOP;
      end else begin
        case (step_q)
          ST_DEV_R: step_q <= (rem_q == '0) ? ST_STOP : ST_READ;
          ST_READ: begin
            rem_q <= rem_q - RW'(1);
            if (rem_q == RW'(1)) step_q <= ST_STOP;
          end
          ST_STOP: begin
            busy_q <= 1'b0;
            done_q <= !fail_q;
          end
          default: step_q <= step_q + 4'd1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst || fifo_clr) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (pop)  rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp_q[AW-1:0]] <= rsp_byte;
endmodule

// File: rtl/edid_burst_rd_chk.sv
module edid_burst_rd_chk #(
  parameter int FIFO_DEPTH = 16
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            reg_we,
  input logic [2:0]                      reg_sel,
  input logic [31:0]                     reg_wdata,
  input logic                            busy,
  input logic                            done,
  input logic                            fifo_rd,
  input logic                            fifo_empty,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
  input logic                            req_valid,
  input logic [1:0]                      req_op,
  input logic [7:0]                      req_byte,
  input logic                            req_last,
  input logic                            rsp_valid
);
  wire srst_wr = reg_we && reg_sel == 3'd0 && reg_wdata[0];
  wire clr_wr  = reg_we && reg_sel == 3'd2 && reg_wdata[31];

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !rsp_valid && !srst_wr |=> req_valid && $stable(req_op) && $stable(req_byte));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_wr |=> !busy && !done && !req_valid && fifo_empty);

  p_stop_ends_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 2'd3 && rsp_valid && !srst_wr |=> !busy);

  p_last_is_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_last |-> req_valid && req_op == 2'd2);

  p_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && fifo_rd && !fifo_empty && !srst_wr && !clr_wr |=> fifo_level == $past(fifo_level) - 1'b1);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> fifo_empty);
endmodule

bind edid_burst_rd edid_burst_rd_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .busy(busy), .done(done), .fifo_rd(fifo_rd), .fifo_empty(fifo_empty),
  .fifo_level(fifo_level), .req_valid(req_valid), .req_op(req_op), .req_byte(req_byte),
  .req_last(req_last), .rsp_valid(rsp_valid)
);

// File: tb/test_edid_burst_rd.sv
module test_edid_burst_rd;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, reg_we = 1'b0, fifo_rd = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        busy, done, fifo_empty, req_valid, req_last;
  logic [7:0]  fifo_data, req_byte;
  logic [4:0]  fifo_level;
  logic [1:0]  req_op;
  logic        rsp_valid = 1'b0, rsp_ack = 1'b0;
  logic [7:0]  rsp_byte = '0;

  edid_burst_rd i_edid_burst_rd (.*);

  int total = 0, bad = 0;
  logic [10:0] log_mem [64];
  int log_n = 0;
  logic [10:0] exp_mem [64];
  int exp_n = 0;

  logic [7:0] t_seg = 0, t_ptr = 0, nack_byte = 8'hFF;
  int t_mode = 0, dly = 0;
  bit t_aphase = 0;

  function automatic logic [7:0] edid_val(input logic [7:0] s, input logic [7:0] p);
    return 8'(s * 29 + p * 7 + 91);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // byte-level master plus display memory model
  initial forever begin
    @(negedge clk);
    if (rsp_valid) begin
      rsp_valid = 1'b0;
      dly = 0;
    end else if (!req_valid) dly = 0;
    else if (++dly == 2) begin
      rsp_ack = 1'b1;
      rsp_byte = 8'h00;
      if (log_n < 64) log_mem[log_n] = {req_op, req_last, req_byte};
      log_n++;
      case (req_op)
        2'd0: t_aphase = 1;
        2'd1: if (t_aphase) begin
                t_aphase = 0;
                if (req_byte == nack_byte) rsp_ack = 1'b0;
                else case (req_byte)
                  8'hC0: t_mode = 1;
                  8'hA0: t_mode = 2;
                  8'hA1: t_mode = 3;
                  default: rsp_ack = 1'b0;
                endcase
              end else if (req_byte == nack_byte) rsp_ack = 1'b0;
              else if (t_mode == 1) t_seg = req_byte;
              else if (t_mode == 2) t_ptr = req_byte;
        2'd2: begin rsp_byte = edid_val(t_seg, t_ptr); t_ptr++; end
        default: t_seg = 0;
      endcase
      rsp_valid = 1'b1;
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic pe(input logic [1:0] op, input bit last, input logic [7:0] b);
    exp_mem[exp_n] = {op, last, b};
    exp_n++;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 3000) begin @(negedge clk); n++; end
    chk(!busy, tag, busy, 0);
  endtask

  task automatic chk_seq(input string tag);
    int mism = 0;
    for (int i = 0; i < exp_n && i < log_n; i++) if (log_mem[i] !== exp_mem[i]) mism++;
    chk(log_n == exp_n && mism == 0, tag, log_n * 256 + mism, exp_n * 256);
  endtask

  task automatic setup(input logic [7:0] s, input logic [7:0] o, input logic [7:0] c, input logic [7:0] cmd);
    wr(1, {s, 8'h60, o, 8'h50});
    wr(3, {24'd0, c});
    wr(4, {24'd0, cmd});
    wr(2, 32'h8000_0000);
  endtask

  task automatic build(input logic [7:0] s, input logic [7:0] o, input int n);
    exp_n = 0;
    if (s != 0) begin pe(0, 0, 0); pe(1, 0, 8'hC0); pe(1, 0, s); end
    pe(0, 0, 0); pe(1, 0, 8'hA0); pe(1, 0, o); pe(0, 0, 0); pe(1, 0, 8'hA1);
    for (int i = 0; i < n; i++) pe(2, i == n - 1, 0);
    pe(3, 0, 0);
  endtask

  task automatic burst(input logic [7:0] s, input logic [7:0] o, input logic [7:0] c);
    int n = (c > 16) ? 16 : c;
    int mism = 0;
    setup(s, o, c, 8'd4);
    build(s, o, n);
    log_n = 0;
    wr(0, 32'hC000_0000);
    chk(busy == 1, "R2 busy after start", busy, 1);
    chk(done == 0, "R8 done cleared on start", done, 0);
    wait_idle("R2 busy self-clears");
    chk(done == 1, "R8 done after success", done, 1);
    chk_seq((s != 0) ? "R3/R6 op trace with segment" : "R4/R6 op trace without segment");
    chk(fifo_level == n, "R5 clamped byte count", fifo_level, n);
    fifo_rd = 1;
    for (int i = 0; i < n; i++) begin
      if (fifo_data !== edid_val(s, 8'(o + i))) mism++;
      @(negedge clk);
    end
    fifo_rd = 0;
    chk(mism == 0 && fifo_empty, "R7 FIFO order and data", mism, 0);
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", total);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !req_valid && fifo_empty, "R1 reset state",
        {busy, done, req_valid, fifo_empty}, 1);

    for (int s = 0; s < 3; s++)
      for (int c = 0; c <= 18; c++) burst(8'(s), 8'h20, 8'(c));
    for (int o = 0; o < 256; o += 16) burst(8'd1, 8'(o), 8'd16);

    // ignored starts
    setup(0, 0, 4, 8'd3);
    log_n = 0;
    wr(0, 32'hC000_0000);
    repeat (6) @(negedge clk);
    chk(!busy && !req_valid && log_n == 0, "R2 other command ignored", log_n, 0);
    wr(4, 32'd4);
    wr(0, 32'h4000_0000);
    repeat (6) @(negedge clk);
    chk(!busy && !req_valid && log_n == 0, "R2 start without enable ignored", log_n, 0);

    // FIFO clear
    setup(0, 8'h10, 4, 8'd4);
    wr(0, 32'hC000_0000);
    wait_idle("R9 burst end");
    chk(fifo_level == 4, "R9 level before clear", fifo_level, 4);
    wr(2, 32'h8000_0000);
    chk(fifo_empty && fifo_level == 0, "R9 FIFO clear", fifo_level, 0);

    // NACK on segment pointer address
    nack_byte = 8'hC0;
    setup(2, 0, 5, 8'd4);
    exp_n = 0; pe(0, 0, 0); pe(1, 0, 8'hC0); pe(3, 0, 0);
    log_n = 0;
    wr(0, 32'hC000_0000);
    wait_idle("R12 nack end");
    chk(!done && fifo_empty, "R12 done stays 0 after nack", done, 0);
    chk_seq("R12 stop after nacked segment pointer");

    // NACK on read address
    nack_byte = 8'hA1;
    setup(0, 8'h40, 5, 8'd4);
    exp_n = 0; pe(0, 0, 0); pe(1, 0, 8'hA0); pe(1, 0, 8'h40); pe(0, 0, 0); pe(1, 0, 8'hA1); pe(3, 0, 0);
    log_n = 0;
    wr(0, 32'hC000_0000);
    wait_idle("R12 nack end");
    chk(!done && fifo_empty, "R12 no reads after nacked read address", fifo_level, 0);
    chk_seq("R12 stop after nacked read address");
    nack_byte = 8'hFF;

    // soft reset mid-command
    setup(1, 0, 16, 8'd4);
    wr(0, 32'hC000_0000);
    repeat (30) @(negedge clk);
    chk(busy && !fifo_empty, "R10 command running before abort", fifo_level, 1);
    wr(0, 32'h0000_0001);
    chk(!busy && !done && !req_valid && fifo_empty, "R10 soft reset abort",
        {busy, done, req_valid, fifo_empty}, 1);
    @(negedge clk);
    t_seg = 0; t_aphase = 0;
    burst(8'd0, 8'h70, 8'd3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule